// File: doc/BRIEF.md
# Speculative Load Ordering Queue

This block lets a core service loads before the memory operations ahead of them in program order have completed, while keeping the result sequentially consistent. Each load the core issues is recorded in a circular buffer in program order, with its tag and the cache-line address it read. A load the core marks as speculative stays open to coherence snoops until it is acknowledged, that is, until every older operation has completed, and until every older entry in the buffer is also acknowledged. Once settled in that way, it retires from the head in program order and is no longer snooped.

If an invalidation hits the line of a load that is still open, the buffer asks the core to squash that load and everything younger, and to reissue from it. The rollback request names the oldest open load that matches. The matching entry and all younger entries leave the buffer on the same clock edge that raises the request. The cache, the coherence engine and the pipeline sit outside the block. The block sees them only through the issue, acknowledge and snoop inputs and the retire and rollback outputs.

Top module: `spec_load_queue`

## Requirements
- R1: Synchronous reset (rst high) empties the buffer. After reset, ld_ready is 1 and ret_valid and rb_valid are 0.
- R2: A load is accepted on a clock edge where ld_valid and ld_ready are both 1. Loads retire in acceptance order. ret_valid is 1 while the head entry is non-speculative, ret_tag gives the head tag, and the entry leaves the buffer on that same edge, one per cycle.
- R3: When DEPTH loads are resident, ld_ready is 0 and a presented load is not accepted.
- R4: A load issued with ld_safe=1, or acknowledged by an ack_valid pulse whose ack_tag equals its tag, becomes non-speculative. An acknowledged load does not retire while an older resident load is still speculative.
- R5: An invalidation (snp_valid with snp_line) that hits an open load raises rb_valid for exactly one cycle on the next clock edge. rb_tag then carries that load's tag, and on that edge the load and every younger entry are removed, so later acknowledgements of them retire nothing.
- R6: When an invalidation hits several open loads, rb_tag names the oldest of them.
- R7: A load is open while it is speculative or while any older resident load is speculative. A load that is acknowledged with all older loads acknowledged is not affected by invalidations.
- R8: An invalidation whose line matches no open load causes no rollback and leaves the buffer unchanged.
- R9: In a cycle in which an invalidation hits an open load, ld_ready is 0 and no load is accepted.
- R10: An acknowledgement whose tag matches no resident speculative load has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load issue request |
| ld_ready | output | 1 | Buffer can accept a load this cycle |
| ld_tag | input | TAG_W | Tag of the issued load |
| ld_line | input | LINE_W | Cache-line address read by the load |
| ld_safe | input | 1 | Load issued with no older operation outstanding |
| ack_valid | input | 1 | Older operations of one load have all completed |
| ack_tag | input | TAG_W | Tag of the load the acknowledgement refers to |
| snp_valid | input | 1 | Coherence invalidation present |
| snp_line | input | LINE_W | Invalidated cache-line address |
| rb_valid | output | 1 | Rollback request, one-cycle pulse |
| rb_tag | output | TAG_W | Oldest tag to squash and reissue from |
| ret_valid | output | 1 | Head load retires this cycle |
| ret_tag | output | TAG_W | Tag of the retiring load |

## Verification
The bench builds the queue with DEPTH=4, TAG_W=6 and LINE_W=12. With only four slots, the full stall is reached after four loads and the ring pointers wrap within the first dozen allocations. A rollback therefore truncates a buffer whose live region crosses the wrap point, and the search for the oldest match must walk from the head across index zero. The narrow tags and lines keep the stimulus readable and do not change the comparator or scan structure.

// File: rtl/slq_pkg.sv
package slq_pkg;

    // Life cycle of one buffer slot
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_SPEC = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_e;

    // Distance of a slot from the head in a power-of-two ring
    function automatic int unsigned ring_age(input int unsigned idx,
                                             input int unsigned head,
                                             input int unsigned depth);
        return (idx + depth - head) % depth;
    endfunction

endpackage

// File: rtl/slq_line_cmp.sv
module slq_line_cmp #(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 26
) (
    input  logic [DEPTH-1:0][LINE_W-1:0] slot_line,
    input  logic                         snp_valid,
    input  logic [LINE_W-1:0]            snp_line,
    output logic [DEPTH-1:0]             line_hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign line_hit[g] = snp_valid && (slot_line[g] == snp_line);
    end
endmodule

// File: rtl/slq_age_scan.sv
module slq_age_scan #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [PTR_W-1:0] head,
    input  logic [DEPTH-1:0] live,
    input  logic [DEPTH-1:0] spec,
    input  logic [DEPTH-1:0] line_hit,
    output logic [DEPTH-1:0] settled,
    output logic             match_any,
    output logic [PTR_W-1:0] match_idx,
    output logic [PTR_W-1:0] match_off
);
    // Walk from oldest to youngest: an entry is settled when it and every
    // older resident entry are non-speculative; the first open hit wins.
    always_comb begin
        logic             older_ok;
        logic [PTR_W-1:0] idx;
        settled   = '0;
        match_any = 1'b0;
        match_idx = '0;
        match_off = '0;
        older_ok  = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PTR_W'(k);
            if (live[idx]) begin
                if (!spec[idx] && older_ok) begin
                    settled[idx] = 1'b1;
                end else if (line_hit[idx] && !match_any) begin
                    match_any = 1'b1;
                    match_idx = idx;
                    match_off = PTR_W'(k);
                end
                if (spec[idx]) older_ok = 1'b0;
            end
        end
    end
endmodule

// File: rtl/spec_load_queue.sv
module spec_load_queue
    import slq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 6,
    parameter int LINE_W = 26,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [LINE_W-1:0] ld_line,
    input  logic              ld_safe,
    input  logic              ack_valid,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    output logic              rb_valid,
    output logic [TAG_W-1:0]  rb_tag,
    output logic              ret_valid,
    output logic [TAG_W-1:0]  ret_tag
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        slot_state_e       st;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] line;
    } slot_t;

    slot_t [DEPTH-1:0]             slots;
    logic  [PTR_W-1:0]             head, tail;
    logic  [CNT_W-1:0]             count;
    logic  [DEPTH-1:0][LINE_W-1:0] slot_line;
    logic  [DEPTH-1:0]             live, spec, line_hit, settled;
    logic                          match_any;
    logic  [PTR_W-1:0]             match_idx, match_off;
    logic                          alloc_fire;

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign slot_line[g] = slots[g].line;
        assign live[g]      = slots[g].st != SLOT_FREE;
        assign spec[g]      = slots[g].st == SLOT_SPEC;
    end

    slq_line_cmp #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_cmp (
        .slot_line (slot_line),
        .snp_valid (snp_valid),
        .snp_line  (snp_line),
        .line_hit  (line_hit)
    );

    slq_age_scan #(.DEPTH(DEPTH)) u_scan (
        .head      (head),
        .live      (live),
        .spec      (spec),
        .line_hit  (line_hit),
        .settled   (settled),
        .match_any (match_any),
        .match_idx (match_idx),
        .match_off (match_off)
    );

    // Rollback outranks allocation; a full ring stalls the core
    assign ld_ready   = (count != FULL_CNT) && !match_any;
    assign alloc_fire = ld_valid && ld_ready;
    assign ret_valid  = slots[head].st == SLOT_DONE;
    assign ret_tag    = slots[head].tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i].st   <= SLOT_FREE;
                slots[i].tag  <= '0;
                slots[i].line <= '0;
            end
            head     <= '0;
            tail     <= '0;
            count    <= '0;
            rb_valid <= 1'b0;
            rb_tag   <= '0;
        end else begin
            rb_valid <= match_any;
            if (match_any) rb_tag <= slots[match_idx].tag;

            for (int i = 0; i < DEPTH; i++) begin
                if (ret_valid && PTR_W'(i) == head) begin
                    slots[i].st <= SLOT_FREE;
                end else if (match_any &&
                             ring_age(i, int'(head), DEPTH) >= int'(match_off)) begin
                    slots[i].st <= SLOT_FREE;
                end else if (alloc_fire && PTR_W'(i) == tail) begin
                    slots[i].st   <= ld_safe ? SLOT_DONE : SLOT_SPEC;
                    slots[i].tag  <= ld_tag;
                    slots[i].line <= ld_line;
                end else if (ack_valid && slots[i].st == SLOT_SPEC &&
                             slots[i].tag == ack_tag) begin
                    slots[i].st <= SLOT_DONE;
                end
            end

            if (ret_valid) head <= head + 1'b1;

            if (match_any) begin
                tail  <= match_idx;
                count <= CNT_W'(match_off) - CNT_W'(ret_valid);
            end else begin
                if (alloc_fire) tail <= tail + 1'b1;
                count <= count + CNT_W'(alloc_fire) - CNT_W'(ret_valid);
            end
        end
    end

    // R1: no rollback is reported straight out of reset
    p_quiet_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rb_valid);

    // R2: each retirement advances the head by exactly one slot
    p_retire_order_r2: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> head == PTR_W'($past(head) + 1'b1));

    // R3: occupancy never exceeds the ring size
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R3: a full ring refuses new loads
    p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (count == FULL_CNT) |-> !ld_ready);

    // R4: only a settled head may retire
    p_retire_settled_r4: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> settled[head]);

    // R5: a rollback follows a snoop and never grows the buffer
    p_rb_after_snoop_r5: assert property (@(posedge clk) disable iff (rst)
        rb_valid |-> ($past(snp_valid) && count <= $past(count)));

    // R9: the cycle that caused a rollback accepted no load
    p_rb_blocks_alloc_r9: assert property (@(posedge clk) disable iff (rst)
        rb_valid |-> !$past(ld_ready));

endmodule

// File: tb/spec_load_queue_bench.sv
module spec_load_queue_bench;
    localparam int DEPTH  = 4;
    localparam int TAG_W  = 6;
    localparam int LINE_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_valid = 1'b0, ld_safe = 1'b0;
    logic              ld_ready;
    logic [TAG_W-1:0]  ld_tag = '0;
    logic [LINE_W-1:0] ld_line = '0;
    logic              ack_valid = 1'b0;
    logic [TAG_W-1:0]  ack_tag = '0;
    logic              snp_valid = 1'b0;
    logic [LINE_W-1:0] snp_line = '0;
    logic              rb_valid, ret_valid;
    logic [TAG_W-1:0]  rb_tag, ret_tag;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    logic [TAG_W-1:0] exp_ret[$];
    logic [TAG_W-1:0] exp_rb[$];

    always #2.5 clk = ~clk;

    spec_load_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_spec_load_queue (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_tag(ld_tag),
        .ld_line(ld_line), .ld_safe(ld_safe),
        .ack_valid(ack_valid), .ack_tag(ack_tag),
        .snp_valid(snp_valid), .snp_line(snp_line),
        .rb_valid(rb_valid), .rb_tag(rb_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compares every retirement and rollback against the scoreboard
    always @(negedge clk) begin
        if (running && !rst) begin
            if (ret_valid) begin
                if (exp_ret.size() == 0) check("R2/R4/R10 unexpected retire", int'(ret_tag), -1);
                else check("R2 retire order", int'(ret_tag), int'(exp_ret.pop_front()));
            end
            if (rb_valid) begin
                if (exp_rb.size() == 0) check("R5/R7/R8 unexpected rollback", int'(rb_tag), -1);
                else check("R5/R6 rollback tag", int'(rb_tag), int'(exp_rb.pop_front()));
            end
        end
    end

    // Driver: one cycle of stimulus; ld_ready is checked mid-cycle when a load is shown
    task automatic step(input bit lv, input int tag, input int line, input bit safe,
                        input bit exp_rdy, input bit av, input int atag,
                        input bit sv, input int sline, input string req);
        ld_valid  = lv;   ld_tag  = TAG_W'(tag);  ld_line = LINE_W'(line); ld_safe = safe;
        ack_valid = av;   ack_tag = TAG_W'(atag);
        snp_valid = sv;   snp_line = LINE_W'(sline);
        @(negedge clk);
        if (lv) check(req, int'(ld_ready), int'(exp_rdy));
        @(posedge clk); #1;
        ld_valid = 1'b0; ack_valid = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic issue(input int tag, input int line, input bit safe, input bit exp_rdy,
                         input string req);
        step(1'b1, tag, line, safe, exp_rdy, 1'b0, 0, 1'b0, 0, req);
    endtask

    task automatic ack(input int tag);
        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, tag, 1'b0, 0, "");
    endtask

    task automatic snoop(input int line);
        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, line, "");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: empty after reset
        check("R1 ld_ready", int'(ld_ready), 1);
        check("R1 ret_valid", int'(ret_valid), 0);
        check("R1 rb_valid", int'(rb_valid), 0);
        @(posedge clk); #1;
        running = 1'b1;

        // R2: safe loads retire in program order
        exp_ret.push_back(6'd1); exp_ret.push_back(6'd2); exp_ret.push_back(6'd3);
        issue(1, 10, 1'b1, 1'b1, "R2 accept 1");
        issue(2, 11, 1'b1, 1'b1, "R2 accept 2");
        issue(3, 12, 1'b1, 1'b1, "R2 accept 3");
        idle(4);

        // R3: four speculative loads fill the ring (pointers wrap)
        issue(4, 20, 1'b0, 1'b1, "R3 accept 4");
        issue(5, 21, 1'b0, 1'b1, "R3 accept 5");
        issue(6, 22, 1'b0, 1'b1, "R3 accept 6");
        issue(7, 23, 1'b0, 1'b1, "R3 accept 7");
        issue(8, 24, 1'b0, 1'b0, "R3 full stall");

        // R4: younger ack waits behind older speculative load
        ack(5);
        idle(2);
        exp_ret.push_back(6'd4); exp_ret.push_back(6'd5);
        ack(4);
        idle(3);

        // R8: unmatched snoop; R10: unknown ack
        snoop(99);
        idle(2);
        ack(40);
        idle(2);

        // R7: acked load behind a speculative one is still snooped
        ack(7);
        idle(2);
        exp_rb.push_back(6'd7);
        snoop(23);
        idle(2);
        exp_ret.push_back(6'd6);
        ack(6);
        idle(2);
        ack(7);          // R5: removed load no longer retires
        idle(2);

        // R6/R9/R5: multi-hit rollback names the oldest and blocks allocation
        issue(10, 30, 1'b0, 1'b1, "R5 accept 10");
        issue(11, 31, 1'b0, 1'b1, "R5 accept 11");
        issue(12, 30, 1'b0, 1'b1, "R6 accept 12");
        exp_rb.push_back(6'd10);
        step(1'b1, 13, 32, 1'b0, 1'b0, 1'b0, 0, 1'b1, 30, "R9 alloc blocked by rollback");
        idle(2);
        ack(10); ack(11); ack(12); ack(13);
        idle(2);

        // R5: buffer emptied by the squash holds four new loads again
        issue(20, 50, 1'b0, 1'b1, "R5 accept 20");
        issue(21, 51, 1'b0, 1'b1, "R5 accept 21");
        issue(22, 52, 1'b0, 1'b1, "R5 accept 22");
        issue(23, 53, 1'b0, 1'b1, "R5 accept 23");
        issue(24, 54, 1'b0, 1'b0, "R3 full after squash");
        exp_ret.push_back(6'd20); exp_ret.push_back(6'd21);
        exp_ret.push_back(6'd22); exp_ret.push_back(6'd23);
        ack(20); ack(21); ack(22); ack(23);
        idle(3);

        // R7: settled load is not rolled back by an invalidation
        exp_ret.push_back(6'd30);
        issue(30, 40, 1'b1, 1'b1, "R7 accept 30");
        snoop(40);
        idle(3);

        running = 1'b0;
        check("R2 retire scoreboard drained", exp_ret.size(), 0);
        check("R5 rollback scoreboard drained", exp_rb.size(), 0);
        finish_run();
    end
endmodule